// File: doc/BRIEF.md
# Frame-Aligned Lane Deskew FIFO

This block is the receive buffer of one lane in a group of parallel byte-stream lanes that must be delivered to logic in a common, frequency-locked read clock with their frames lined up. Each lane carries 32-bit words with two marker bits: a frame-pulse flag and a payload-envelope flag. The buffer holds 24 words, which is roughly 768 bits of tolerable lane-to-lane skew.

The write side does nothing until the upstream framer reports that it is in frame and marks a word as holding the first framing byte of a frame. That word goes into slot 0, and every later write-clock cycle stores the next word in the following slot, with a wrap after slot 23. The read side waits for a start pulse from a group controller, which pulses the start inputs of all lanes in a group together. From then on it reads one word per read-clock cycle, starting at slot 0, so all lanes of the group emit their frame starts in the same cycle.

A 6-bit write count is passed to the read clock domain as a Gray code through two flops. The read side subtracts its own read count from it and reports the result as the lane's skew, and it raises a sticky alarm when that skew passes a programmable limit.

Top module: `lane_deskew_fifo`

## Requirements
- R1: After both lane resets have been held low, `rd_valid`, `rd_skew` and `rd_alarm` are all 0.
- R2: A word is stored only once `wr_in_sync` and `wr_a1` are both 1 at the same write edge. Words seen with only one of the two at 1 are dropped and never appear at the output.
- R3: The anchoring word, taken when `wr_in_sync` and `wr_a1` are both 1, is written to slot 0. It is the first word the read side outputs after its start.
- R4: After anchoring, every write edge stores the next word in the next slot, wrapping from slot 23 to 0. A later `wr_a1` does not re-anchor, so the output is the exact input sequence.
- R5: Reading starts only after `rd_start` is sampled at 1, and the first read is from slot 0. `rd_valid` stays 0 in the cycle after that edge and is 1 from the cycle after that. It stays 1 on every later read edge. A further `rd_start` while reading has no effect.
- R6: `rd_fp` and `rd_spe` carry the marker bits that were stored with the word shown on `rd_data`.
- R7: While reading, `rd_skew` is the synchronized write count minus the read count. This is at most 5 below the true count of words written minus words output. While waiting for the start pulse, `rd_skew` is 0.
- R8: `rd_alarm` is set when the lane is reading and `rd_skew` is greater than `rd_limit`. It stays set until `rd_alm_clr` is 1, which clears it at the next edge.
- R9: The write count crosses clock domains as a Gray code that changes in exactly one bit per stored word and holds otherwise.
- R10: A lane reset returns both pointers to slot 0 and re-arms the write side. The first word output after the next start is the next anchoring word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write (recovered lane) clock |
| wr_rst_n | input | 1 | Synchronous active-low lane reset, write domain |
| wr_in_sync | input | 1 | Framer is in frame |
| wr_a1 | input | 1 | This word holds the first framing byte of a frame |
| wr_fp | input | 1 | Frame-pulse marker stored with the word |
| wr_spe | input | 1 | Payload-envelope marker stored with the word |
| wr_data | input | 32 | Lane data word |
| rd_clk | input | 1 | Common read clock |
| rd_rst_n | input | 1 | Synchronous active-low lane reset, read domain |
| rd_start | input | 1 | Group start pulse |
| rd_alm_clr | input | 1 | Clears the sticky skew alarm |
| rd_limit | input | 6 | Skew alarm threshold in words |
| rd_valid | output | 1 | Output word valid |
| rd_data | output | 32 | Output data word |
| rd_fp | output | 1 | Frame-pulse marker of the output word |
| rd_spe | output | 1 | Payload-envelope marker of the output word |
| rd_skew | output | 6 | Write-to-read distance in words |
| rd_alarm | output | 1 | Sticky skew-over-limit alarm |

## Verification
The assertions check on every cycle the local rules:
- the write side stays idle without frame sync, anchors at slot 0 and wraps after slot 23;
- the Gray count moves by exactly one bit per stored word;
- a start in the waiting state opens reading at slot 0;
- the skew reads 0 while waiting;
- the alarm rises only after an over-limit skew, holds, and falls on a clear.

Only the bench scenarios can show the end-to-end facts. These are that the first word out is the anchoring word after random pre-sync traffic, that the stream continues unbroken across later framing markers and repeated starts, that the reported skew tracks the real distance within the synchronizer lag, and that a lane reset re-arms the anchor.

// File: rtl/lane_dsk_pkg.sv
// Package: shared state types for the lane deskew FIFO.
// Assumes: nothing beyond SystemVerilog 2017.
package lane_dsk_pkg;
    typedef enum logic {WR_ARM = 1'b0, WR_RUN = 1'b1} wr_state_t;
    typedef enum logic {RD_WAIT = 1'b0, RD_RUN = 1'b1} rd_state_t;
endpackage

// File: rtl/lane_dsk_sync.sv
// Module: two-flop synchronizer for a multi-bit value that changes in at
// most one bit per source clock (a Gray code).
// Assumes: the source holds each value for at least one destination cycle.
module lane_dsk_sync #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    logic [W-1:0] stage1;

    // two register stages in the destination domain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            d_out  <= '0;
        end else begin
            stage1 <= d_in;
            d_out  <= stage1;
        end
    end
endmodule

// File: rtl/lane_dsk_wr.sv
// Module: write control. Stays armed until frame sync and the first framing
// word coincide, writes that word to slot 0, then one word per cycle.
// Assumes: write and read clocks share a frequency, so no full/empty stop.
module lane_dsk_wr
    import lane_dsk_pkg::*;
#(
    parameter int DEPTH = 24,
    parameter int AW    = 5,
    parameter int CW    = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_sync,
    input  logic          a1,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [CW-1:0] wgray
);
    wr_state_t     state;
    logic [CW-1:0] wcnt;
    logic [CW-1:0] wcnt_nx;

    // write enable: always once anchored, else only on the anchor word
    assign we      = (state == WR_RUN) || (in_sync && a1);
    assign wcnt_nx = wcnt + 1'b1;

    // pointer, count and Gray count update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= WR_ARM;
            waddr <= '0;
            wcnt  <= '0;
            wgray <= '0;
        end else if (we) begin
            state <= WR_RUN;
            waddr <= (waddr == AW'(DEPTH - 1)) ? '0 : waddr + 1'b1;
            wcnt  <= wcnt_nx;
            wgray <= wcnt_nx ^ (wcnt_nx >> 1);
        end
    end

    p_idle_no_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WR_ARM && !in_sync) |-> !we);
    p_anchor_slot0_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WR_ARM && we) |-> (waddr == '0));
    p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (we && waddr == AW'(DEPTH - 1)) |=> (waddr == '0));
    p_gray_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> ($countones(wgray ^ $past(wgray)) == 1));
    p_gray_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(wgray));
endmodule

// File: rtl/lane_dsk_rd.sv
// Module: read control. Waits for the group start pulse, then reads one word
// per cycle from slot 0. Measures skew from the synchronized Gray count and
// keeps a sticky over-limit alarm.
// Assumes: the group controller starts reading after the anchor is stored.
module lane_dsk_rd
    import lane_dsk_pkg::*;
#(
    parameter int DW    = 32,
    parameter int DEPTH = 24,
    parameter int AW    = 5,
    parameter int CW    = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          clr,
    input  logic [CW-1:0] limit,
    input  logic [CW-1:0] wgray_s,
    input  logic [DW+1:0] rword,
    output logic [AW-1:0] raddr,
    output logic          valid,
    output logic [DW-1:0] dout,
    output logic          fp,
    output logic          spe,
    output logic [CW-1:0] skew,
    output logic          alarm
);
    rd_state_t     state;
    logic [CW-1:0] rcnt;
    logic [CW-1:0] wbin;

    // Gray to binary: each bit is the parity of the bits at and above it
    always_comb begin
        for (int i = 0; i < CW; i++) begin
            wbin[i] = ^(wgray_s >> i);
        end
    end

    // read sequencing, output register and skew measure
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RD_WAIT;
            raddr <= '0;
            rcnt  <= '0;
            valid <= 1'b0;
            dout  <= '0;
            fp    <= 1'b0;
            spe   <= 1'b0;
            skew  <= '0;
        end else if (state == RD_WAIT) begin
            valid <= 1'b0;
            skew  <= '0;
            if (start) begin
                state <= RD_RUN;
            end
        end else begin
            {fp, spe, dout} <= rword;
            valid <= 1'b1;
            raddr <= (raddr == AW'(DEPTH - 1)) ? '0 : raddr + 1'b1;
            rcnt  <= rcnt + 1'b1;
            skew  <= wbin - rcnt;
        end
    end

    // sticky alarm, clear has priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm <= 1'b0;
        end else if (clr) begin
            alarm <= 1'b0;
        end else if (state == RD_RUN && skew > limit) begin
            alarm <= 1'b1;
        end
    end

    p_start_slot0_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RD_WAIT && start) |=> (state == RD_RUN && raddr == '0));
    p_wait_no_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RD_WAIT) |=> !valid);
    p_skew_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RD_WAIT) |=> (skew == '0));
    p_alarm_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm && !clr) |=> alarm);
    p_alarm_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !alarm);
    p_alarm_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm) |-> $past(skew > limit));
endmodule

// File: rtl/lane_deskew_fifo.sv
// Module: top of one lane's deskew FIFO. Holds the word store and connects
// write control, the Gray-count synchronizer and read control.
// Assumes: both lane resets are asserted together for a lane reset.
module lane_deskew_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 24
) (
    input  logic                        wr_clk,
    input  logic                        wr_rst_n,
    input  logic                        wr_in_sync,
    input  logic                        wr_a1,
    input  logic                        wr_fp,
    input  logic                        wr_spe,
    input  logic [DW-1:0]               wr_data,
    input  logic                        rd_clk,
    input  logic                        rd_rst_n,
    input  logic                        rd_start,
    input  logic                        rd_alm_clr,
    input  logic [$clog2(DEPTH):0]      rd_limit,
    output logic                        rd_valid,
    output logic [DW-1:0]               rd_data,
    output logic                        rd_fp,
    output logic                        rd_spe,
    output logic [$clog2(DEPTH):0]      rd_skew,
    output logic                        rd_alarm
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [DW+1:0] mem [DEPTH];
    logic          we;
    logic [AW-1:0] waddr;
    logic [AW-1:0] raddr;
    logic [CW-1:0] wgray;
    logic [CW-1:0] wgray_s;
    logic [DW+1:0] rword;

    lane_dsk_wr #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_wr (
        .clk(wr_clk), .rst_n(wr_rst_n), .in_sync(wr_in_sync), .a1(wr_a1),
        .we(we), .waddr(waddr), .wgray(wgray)
    );

    // word store with marker bits, written in the write domain
    always_ff @(posedge wr_clk) begin
        if (we) begin
            mem[waddr] <= {wr_fp, wr_spe, wr_data};
        end
    end

    assign rword = mem[raddr];

    lane_dsk_sync #(.W(CW)) u_sync (
        .clk(rd_clk), .rst_n(rd_rst_n), .d_in(wgray), .d_out(wgray_s)
    );

    lane_dsk_rd #(.DW(DW), .DEPTH(DEPTH), .AW(AW), .CW(CW)) u_rd (
        .clk(rd_clk), .rst_n(rd_rst_n), .start(rd_start), .clr(rd_alm_clr),
        .limit(rd_limit), .wgray_s(wgray_s), .rword(rword), .raddr(raddr),
        .valid(rd_valid), .dout(rd_data), .fp(rd_fp), .spe(rd_spe),
        .skew(rd_skew), .alarm(rd_alarm)
    );

    p_raddr_range_r4: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        raddr < AW'(DEPTH));
endmodule

// File: tb/sim_lane_deskew_fifo.sv
module sim_lane_deskew_fifo;
    localparam int DW = 32;

    logic          wr_clk = 1'b0, rd_clk = 1'b0;
    logic          wr_rst_n = 1'b0, rd_rst_n = 1'b0;
    logic          wr_in_sync = 1'b0, wr_a1 = 1'b0, wr_fp = 1'b0, wr_spe = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_start = 1'b0, rd_alm_clr = 1'b0;
    logic [5:0]    rd_limit = 6'd63;
    logic          rd_valid, rd_fp, rd_spe, rd_alarm;
    logic [DW-1:0] rd_data;
    logic [5:0]    rd_skew;

    int total = 0;
    int bad = 0;
    int wpush = 0;
    int nval = 0;
    bit launched = 1'b0;
    bit launch_req = 1'b0;
    bit first_word = 1'b1;
    logic [DW+1:0] expq[$];

    lane_deskew_fifo u0 (.*);

    always #10 wr_clk = ~wr_clk;
    initial begin
        #7;
        forever #10 rd_clk = ~rd_clk;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit skew_ok(input int written, input int readn, input int sk);
        int d;
        d = written - readn - sk;
        return (d >= 0) && (d <= 5);
    endfunction

    // write stream driver
    initial begin
        forever begin
            @(negedge wr_clk);
            if (!launched) begin
                if (launch_req) begin
                    wr_in_sync = 1'b1; wr_a1 = 1'b1;
                    wr_data = $urandom; wr_fp = 1'b1; wr_spe = 1'($urandom);
                    expq.push_back({wr_fp, wr_spe, wr_data});
                    wpush++;
                    launched = 1'b1;
                end else begin
                    // pre-anchor traffic: never both sync and framing mark (R2)
                    wr_in_sync = 1'($urandom);
                    wr_a1 = wr_in_sync ? 1'b0 : 1'($urandom);
                    wr_data = $urandom; wr_fp = 1'($urandom); wr_spe = 1'($urandom);
                end
            end else begin
                wr_in_sync = 1'b1;
                wr_a1 = (($urandom % 8) == 0);
                wr_data = $urandom; wr_fp = 1'($urandom); wr_spe = 1'($urandom);
                expq.push_back({wr_fp, wr_spe, wr_data});
                wpush++;
            end
        end
    end

    // output checker against the expected word queue
    initial begin
        forever begin
            @(negedge rd_clk);
            if (rd_valid) begin
                if (expq.size() == 0) begin
                    chk(1'b0, "R4 output with nothing written", longint'(rd_data), 0);
                end else begin
                    logic [DW+1:0] e;
                    e = expq.pop_front();
                    if (first_word)
                        chk({rd_fp, rd_spe, rd_data} == e, "R3 first word is anchor",
                            longint'({rd_fp, rd_spe, rd_data}), longint'(e));
                    else
                        chk({rd_fp, rd_spe, rd_data} == e, "R4 R6 word and markers in order",
                            longint'({rd_fp, rd_spe, rd_data}), longint'(e));
                    first_word = 1'b0;
                end
                nval++;
            end
        end
    end

    task automatic lane_reset();
        @(negedge rd_clk);
        wr_rst_n = 1'b0; rd_rst_n = 1'b0;
        launch_req = 1'b0; launched = 1'b0;
        repeat (5) @(negedge rd_clk);
        expq.delete(); wpush = 0; nval = 0; first_word = 1'b1;
        rd_limit = 6'd63;
        wr_rst_n = 1'b1; rd_rst_n = 1'b1;
        @(negedge rd_clk);
        chk(rd_valid == 1'b0, "R1 R10 valid after reset", longint'(rd_valid), 0);
        chk(rd_skew == 6'd0, "R1 R10 skew after reset", longint'(rd_skew), 0);
        chk(rd_alarm == 1'b0, "R1 R10 alarm after reset", longint'(rd_alarm), 0);
    endtask

    task automatic scenario(input int d, input int pre);
        repeat (pre) @(negedge rd_clk);
        chk(rd_valid == 1'b0, "R2 R5 no output before start", longint'(rd_valid), 0);
        chk(rd_skew == 6'd0, "R7 skew zero while waiting", longint'(rd_skew), 0);
        launch_req = 1'b1;
        while (wpush < d) @(negedge rd_clk);
        rd_start = 1'b1;
        @(negedge rd_clk);
        rd_start = 1'b0;
        chk(rd_valid == 1'b0, "R5 valid low one cycle after start", longint'(rd_valid), 0);
        @(negedge rd_clk);
        chk(rd_valid == 1'b1, "R5 valid high two cycles after start", longint'(rd_valid), 1);
        repeat (30) @(negedge rd_clk);
        chk(skew_ok(wpush, nval, int'(rd_skew)), "R7 skew tracks distance",
            longint'(rd_skew), longint'(wpush - nval));
        // second start while reading is ignored
        rd_start = 1'b1;
        @(negedge rd_clk);
        rd_start = 1'b0;
        repeat (4) @(negedge rd_clk);
        chk(rd_valid == 1'b1, "R5 repeated start keeps reading", longint'(rd_valid), 1);
        chk(skew_ok(wpush, nval, int'(rd_skew)), "R5 R7 skew unchanged by restart",
            longint'(rd_skew), longint'(wpush - nval));
        chk(rd_alarm == 1'b0, "R8 no alarm under high limit", longint'(rd_alarm), 0);
        // skew is at least d-6, so a limit of d-9 trips the alarm
        rd_limit = 6'(d - 9);
        repeat (5) @(negedge rd_clk);
        chk(rd_alarm == 1'b1, "R8 alarm over limit", longint'(rd_alarm), 1);
        rd_limit = 6'd63;
        repeat (5) @(negedge rd_clk);
        chk(rd_alarm == 1'b1, "R8 alarm sticky", longint'(rd_alarm), 1);
        rd_alm_clr = 1'b1;
        @(negedge rd_clk);
        rd_alm_clr = 1'b0;
        repeat (3) @(negedge rd_clk);
        chk(rd_alarm == 1'b0, "R8 alarm cleared", longint'(rd_alarm), 0);
        repeat (60) @(negedge rd_clk);
        chk(nval > 90, "R4 R5 continuous read", longint'(nval), 91);
    endtask

    // main sequence
    initial begin
        int seed_v;
        seed_v = $urandom(32'd24681357);
        lane_reset();
        scenario(14, 9);
        lane_reset();
        scenario(12 + int'($urandom % 7), 5 + int'($urandom % 10));
        lane_reset();
        scenario(18, 3);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge wr_clk);
        total++;
        bad++;
        $display("FAIL watchdog R5 actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule